// File: doc/BRIEF.md
# Unaligned Quadword Load Assembler

This block returns a 64-bit little-endian quadword that may start at any byte address, using a memory port that can only read whole aligned 64-bit words. A request carries a byte address. The block then makes two aligned reads. The first read fetches the word that holds the addressed byte. The second read fetches the word that holds the byte seven positions further on. The first word is shifted down so that the addressed byte becomes byte 0. The second word is shifted up so that it fills the byte lanes left empty by the first. The two parts are combined with a bitwise OR, and the result is presented with a one-cycle valid strobe.

The second read uses address plus seven, not plus eight. When the address is already aligned, both reads therefore hit the same word, and nothing beyond that word is ever touched. The memory side holds a read enable and an aligned address until the memory answers with a valid strobe. The memory latency may be any number of cycles.

Top module: `uqx_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `res_valid` and `mem_rd_en` are 0.
- R2: The first read of a request is issued at the request address with its three low bits cleared. `mem_rd_en` stays high and `mem_rd_addr` stays stable until `mem_rd_valid` is returned.
- R3: The second read is issued at (request address + 7) with its three low bits cleared. Each request makes exactly two reads.
- R4: Bits [8i+7:8i] of `res_data` equal the memory byte at request address + i, for i = 0..7, for every offset addr[2:0] from 0 to 7.
- R5: For an aligned address (addr[2:0] = 0), both reads address the same word and `res_data` equals that word unchanged.
- R6: When a request crosses into the next word, including a request in the last word of a 4 KB region, the second read addresses the following word (the first word of the next region), and the result is still correct.
- R7: `res_valid` is high for exactly one cycle. This is the cycle after the edge that accepts the second read's data. With memory latency L, it is seen 2L+2 falling edges after the request is driven.
- R8: A `req_valid` that arrives while a request is in progress is ignored. The result of the current request is unchanged, and no further reads or results follow.
- R9: `res_data` holds its value after the strobe until the next result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a load; accepted only when idle |
| req_addr | input | 64 | Byte address of the quadword |
| mem_rd_en | output | 1 | Aligned read request, held until answered |
| mem_rd_addr | output | 64 | Aligned read address, low three bits zero |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 64 | Aligned word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 64 | Assembled quadword |

## Verification
The bench drives each request at a falling edge and models the memory with a chosen latency L of 1 to 3 cycles. It counts falling edges from the request until `res_valid` appears and requires the strobe at exactly 2L+2, then requires it to be low one edge later. The read addresses are logged as the memory answers and are compared after the result arrives. For the ignore and hold cases, the bench watches `mem_rd_en`, `res_valid` and `res_data` for a fixed window of cycles after the strobe.

// File: rtl/uqx_pkg.sv
package uqx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_LO = 2'd1,
    ST_READ_HI = 2'd2,
    ST_DONE    = 2'd3
  } uqx_state_e;
endpackage

// File: rtl/uqx_rst_sync.sv
module uqx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/uqx_seq.sv
module uqx_seq
  import uqx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rd_valid,
  output logic accept,
  output logic busy,
  output logic rd_en,
  output logic hi_phase,
  output logic cap_lo,
  output logic cap_res,
  output logic res_valid
);
  uqx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_READ_LO;
      ST_READ_LO: if (rd_valid)  state_d = ST_READ_HI;
      ST_READ_HI: if (rd_valid)  state_d = ST_DONE;
      ST_DONE:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != ST_IDLE);
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign rd_en     = (state_q == ST_READ_LO) || (state_q == ST_READ_HI);
  assign hi_phase  = (state_q == ST_READ_HI);
  assign cap_lo    = (state_q == ST_READ_LO) && rd_valid;
  assign cap_res   = (state_q == ST_READ_HI) && rd_valid;
  assign res_valid = (state_q == ST_DONE);

  // R7: strobe lasts one cycle
  assert_res_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3: every answered low read is followed by a high-phase read
  assert_hi_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |=> (rd_en && hi_phase));
endmodule

// File: rtl/uqx_extract.sv
module uqx_extract #(
  parameter int DATA_W    = 64,
  parameter bit HIGH_SIDE = 1'b0,
  localparam int BYTES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] part
);
  generate
    if (!HIGH_SIDE) begin : g_low
      logic [OFF_W+2:0] sh_lo;
      assign sh_lo = {off, 3'b000};
      assign part  = word >> sh_lo;
    end else begin : g_high
      logic [OFF_W:0]   fill;
      logic [OFF_W+3:0] sh_hi;
      assign fill  = (OFF_W+1)'(BYTES) - {1'b0, off};
      assign sh_hi = {fill, 3'b000};
      assign part  = (off == '0) ? '0 : (word << sh_hi);
    end
  endgenerate
endmodule

// File: rtl/uqx_unit.sv
module uqx_unit #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic rst_sync_n;
  logic accept, busy, hi_phase, cap_lo, cap_res;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_far;
  logic [DATA_W-1:0] lo_q, lo_d, res_q, res_d;
  logic [DATA_W-1:0] lo_part, hi_part;
  logic [OFF_W-1:0]  off;

  uqx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  uqx_seq i_seq (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .rd_valid(mem_rd_valid), .accept(accept), .busy(busy),
    .rd_en(mem_rd_en), .hi_phase(hi_phase), .cap_lo(cap_lo),
    .cap_res(cap_res), .res_valid(res_valid)
  );

  assign off      = addr_q[OFF_W-1:0];
  assign addr_far = addr_q + ADDR_W'(BYTES - 1);

  always_comb begin
    if (hi_phase) mem_rd_addr = {addr_far[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    else          mem_rd_addr = {addr_q[ADDR_W-1:OFF_W],   {OFF_W{1'b0}}};
  end

  uqx_extract #(.DATA_W(DATA_W), .HIGH_SIDE(1'b0)) i_ext_lo (
    .word(lo_q), .off(off), .part(lo_part)
  );
  uqx_extract #(.DATA_W(DATA_W), .HIGH_SIDE(1'b1)) i_ext_hi (
    .word(mem_rd_data), .off(off), .part(hi_part)
  );

  always_comb begin
    addr_d = addr_q;
    lo_d   = lo_q;
    res_d  = res_q;
    if (accept)  addr_d = req_addr;
    if (cap_lo)  lo_d   = mem_rd_data;
    if (cap_res) res_d  = lo_part | hi_part;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      lo_q   <= '0;
      res_q  <= '0;
    end else begin
      addr_q <= addr_d;
      lo_q   <= lo_d;
      res_q  <= res_d;
    end
  end

  assign res_data = res_q;

  // R2: reads are aligned
  assert_rd_aligned_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_en |-> (mem_rd_addr[OFF_W-1:0] == '0));

  // R2: request held stable until answered
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

  // R8: a request while busy leaves the captured address alone
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && req_valid) |=> $stable(addr_q));

  // R5: aligned request passes the word through unchanged
  assert_aligned_pass_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_res && off == '0) |=> (res_data == $past(mem_rd_data)));

  // R9: result held between strobes
  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_res |=> $stable(res_data));
endmodule

// File: tb/test_uqx_unit.sv
module test_uqx_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        mem_rd_en;
  logic [63:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_data;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  int mem_lat = 1;
  int wait_cnt = 0;
  int rd_cnt = 0;
  logic [63:0] rd_log [4];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uqx_unit i_uqx_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [7:0] byte_at(logic [63:0] a);
    logic [63:0] v;
    v = a * 64'd37 + (a >> 8) * 64'd11 + (a >> 12) * 64'd3 + 64'd5;
    return v[7:0];
  endfunction

  function automatic logic [63:0] quad_at(logic [63:0] a);
    logic [63:0] q;
    for (int i = 0; i < 8; i++) q[8*i +: 8] = byte_at(a + 64'(i));
    return q;
  endfunction

  function automatic logic [63:0] align(logic [63:0] a);
    return {a[63:3], 3'b000};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers a held read after mem_lat falling edges
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        mem_rd_valid = 1'b0;
        wait_cnt = 0;
      end else if (mem_rd_en) begin
        wait_cnt++;
        if (wait_cnt >= mem_lat) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = quad_at(align(mem_rd_addr));
          if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
          rd_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  // full access with timing, data and address checks (R2,R3,R4,R7)
  task automatic run_access(logic [63:0] a, int lat, string req);
    int cyc;
    mem_lat = lat;
    rd_cnt  = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    cyc = 0;
    while (cyc < 40) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (res_valid) break;
    end
    check(cyc == 2*lat + 2, "R7 strobe cycle", 64'(cyc), 64'(2*lat + 2));
    check(res_data == quad_at(a), req, res_data, quad_at(a));
    check(rd_cnt == 2, "R3 read count", 64'(rd_cnt), 64'd2);
    check(rd_log[0] == align(a), "R2 first read addr", rd_log[0], align(a));
    check(rd_log[1] == align(a + 64'd7), "R3 second read addr", rd_log[1], align(a + 64'd7));
    @(negedge clk);
    check(!res_valid, "R7 one-cycle strobe", 64'(res_valid), 64'd0);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    check(!res_valid && !mem_rd_en, "R1 in reset", {62'd0, res_valid, mem_rd_en}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!res_valid && !mem_rd_en, "R1 after release", {62'd0, res_valid, mem_rd_en}, 64'd0);
  endtask

  task automatic test_offsets;
    for (int o = 0; o < 8; o++) run_access(64'h0000_0000_0001_2340 + 64'(o), 1, "R4 offset sweep");
    for (int o = 0; o < 8; o++) run_access(64'h0000_7A00_0000_0B18 + 64'(o), 3, "R4 offset sweep lat3");
  endtask

  task automatic test_aligned;
    run_access(64'h0000_0000_0000_4560, 2, "R5 aligned pass");
    check(rd_log[0] == rd_log[1], "R5 same word twice", rd_log[1], rd_log[0]);
    check(res_data == quad_at(align(64'h4560)), "R5 word unchanged", res_data, quad_at(64'h4560));
  endtask

  task automatic test_region_edge;
    for (int o = 0; o < 8; o++) begin
      run_access(64'h0000_0000_0000_2FF8 + 64'(o), 2, "R6 region edge");
      if (o != 0)
        check(rd_log[1] == 64'h3000, "R6 next region word", rd_log[1], 64'h3000);
    end
  endtask

  task automatic test_busy_ignore;
    logic [63:0] a = 64'h0000_0000_0000_0913;
    int cyc;
    bit extra;
    mem_lat = 2;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_addr  = 64'h0000_0000_0000_5555;
    cyc = 1;
    while (cyc < 40 && !res_valid) begin
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check(res_data == quad_at(a), "R8 in-flight result kept", res_data, quad_at(a));
    extra = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (res_valid || mem_rd_en) extra = 1'b1;
    end
    check(!extra, "R8 no extra activity", 64'(extra), 64'd0);
    check(rd_cnt == 2, "R8 read count", 64'(rd_cnt), 64'd2);
  endtask

  task automatic test_hold;
    logic [63:0] a = 64'h0000_0000_0000_0C0D;
    bit moved;
    run_access(a, 1, "R4 before hold");
    moved = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (res_data != quad_at(a)) moved = 1'b1;
    end
    check(!moved, "R9 result held", res_data, quad_at(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_offsets();
    test_aligned();
    test_region_edge();
    test_busy_ignore();
    test_hold();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule